// File: doc/BRIEF.md
# Raster line-compare interrupt unit

This block runs the horizontal and vertical raster counters of a video display and derives the horizontal and vertical blanking indications from them. A CPU programs a target line and a vertical scroll offset through a register-write port. When the raster finishes the line whose scrolled memory line number equals the target, a sticky line flag is raised at the first column of the following line. An optional level-sensitive interrupt follows that flag. Software then reads the flag through a status port. The status port has a selector register that chooses which status word is returned. Reading the flag's status word clears the flag.

The match is made in memory-line terms, so a program that moves the vertical scroll keeps its split at the same screen line by adding the scroll value to the target. The current column and line counters are exported so that other display blocks can follow the raster.

Top module: `raster_split_irq`

## Requirements
- R1: `hcount` counts 0 to 341 and wraps to 0. `vcount` advances by one on each wrap of `hcount` and wraps from 261 to 0. Reset puts both counters at 0.
- R2: `hblank` is 1 when `hcount` < 43 or `hcount` >= 299, and is 0 otherwise. Status word 2 bit 5 carries the same value.
- R3: `vblank` is 1 when `vcount` >= 212, and is 0 otherwise. Status word 2 bit 6 carries the same value.
- R4: The line flag (status word 1 bit 0) becomes 1 in the cycle where `hcount` = 0 on the line that follows a line L with (L + register 23) mod 256 = register 19. The flag does not become 1 before that cycle.
- R5: Once set, the line flag stays 1 until a read of status word 1 clears it.
- R6: A cycle with `rd_en` = 1 while register 15 = 1 returns the flag, and the flag reads 0 from the next cycle onward. If a new match sets the flag in that same cycle, the set wins.
- R7: `irq` is 1 exactly while the line flag is 1 and register 0 bit 4 is 1. With bit 4 at 0, the flag still sets but `irq` stays 0.
- R8: Status word 0, any selector value above 2, and all undefined bits of words 1 and 2 read as 0. Reads with those selections leave the line flag unchanged.
- R9: A register write takes effect from the next cycle. After reset, registers 0, 15, 19 and 23 are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 6 | Register index for the write |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Status read strobe; marks a read that clears on read |
| rd_data | output | 8 | Selected status word, presented in every cycle |
| irq | output | 1 | Level-sensitive line interrupt |
| hcount | output | 9 | Current column |
| vcount | output | 9 | Current line |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |

## Verification
The hardest case to reach is a status read that falls in the same clock as the end-of-line match, because the set and the clear then compete. The bench lets the free-running counters reach the last column of the matching line and pulses `rd_en` in exactly that cycle. It then peeks at the flag on the first column of the next line. The bench reaches scrolled matches by moving the scroll so that the target lies some lines past the current line. It lets the raster run through the end of the frame to observe both counter wraps.

// File: rtl/raster_pkg.sv
package raster_pkg;
   // register indices decoded by the write port
   localparam int unsigned REG_CTRL    = 0;
   localparam int unsigned REG_STSEL   = 15;
   localparam int unsigned REG_SPLIT   = 19;
   localparam int unsigned REG_VSCROLL = 23;
   // bit positions inside the registers and status words
   localparam int unsigned IRQ_EN_BIT  = 4;
   localparam int unsigned LINE_FLAG_BIT = 0;
   localparam int unsigned HB_BIT      = 5;
   localparam int unsigned VB_BIT      = 6;
   // status selections
   localparam logic [7:0] SEL_LINE   = 8'd1;
   localparam logic [7:0] SEL_BLANK  = 8'd2;
endpackage

// File: rtl/raster_timing.sv
module raster_timing #(
   parameter int H_TOTAL  = 342,
   parameter int H_ACTIVE = 256,
   parameter int H_LEFT   = 43,
   parameter int V_TOTAL  = 262,
   parameter int V_ACTIVE = 212,
   localparam int HW = $clog2(H_TOTAL),
   localparam int VW = $clog2(V_TOTAL)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [HW-1:0] hcnt,
   output logic [VW-1:0] vcnt,
   output logic          line_end,
   output logic          hblank,
   output logic          vblank
);
   localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
   localparam logic [HW-1:0] H_BEG  = HW'(H_LEFT);
   localparam logic [HW-1:0] H_END  = HW'(H_LEFT + H_ACTIVE);
   localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
   localparam logic [VW-1:0] V_BEG  = VW'(V_ACTIVE);

   generate
      if (H_LEFT + H_ACTIVE >= H_TOTAL) begin : g_bad_h
         $error("raster_timing: active columns do not fit in the line");
      end
      if (V_ACTIVE >= V_TOTAL) begin : g_bad_v
         $error("raster_timing: active lines do not fit in the frame");
      end
      if (V_TOTAL < 256) begin : g_short_frame
         $error("raster_timing: frame must cover the 8-bit line space");
      end
   endgenerate

   assign line_end = (hcnt == H_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hcnt <= '0;
         vcnt <= '0;
      end else if (line_end) begin
         hcnt <= '0;
         vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end

   assign hblank = (hcnt < H_BEG) || (hcnt >= H_END);
   assign vblank = (vcnt >= V_BEG);

   AST_HCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      hcnt <= H_LAST);                                              // R1
   AST_VCNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (line_end && vcnt == V_LAST) |=> (vcnt == '0 && hcnt == '0));  // R1
   AST_VB_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vblank) |-> (vcnt == V_BEG && hcnt == '0));             // R3
endmodule

// File: rtl/raster_regs.sv
module raster_regs
   import raster_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   output logic             irq_en,
   output logic [7:0]       st_sel,
   output logic [7:0]       split_line,
   output logic [7:0]       vscroll
);
   generate
      if ((1 << IDX_W) <= REG_VSCROLL) begin : g_bad_idx
         $error("raster_regs: index width cannot reach every register");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_en     <= 1'b0;
         st_sel     <= '0;
         split_line <= '0;
         vscroll    <= '0;
      end else if (wr_en) begin
         case (wr_idx)
            IDX_W'(REG_CTRL):    irq_en     <= wr_data[IRQ_EN_BIT];
            IDX_W'(REG_STSEL):   st_sel     <= wr_data;
            IDX_W'(REG_SPLIT):   split_line <= wr_data;
            IDX_W'(REG_VSCROLL): vscroll    <= wr_data;
            default: ;
         endcase
      end
   end

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(REG_SPLIT)) |=> split_line == $past(wr_data)); // R9
endmodule

// File: rtl/raster_line_cmp.sv
module raster_line_cmp (
   input  logic [7:0] line_lo,
   input  logic [7:0] vscroll,
   input  logic [7:0] split_line,
   input  logic       line_end,
   output logic       hit
);
   logic [7:0] mem_line;

   // memory line number wraps in 8 bits
   assign mem_line = line_lo + vscroll;
   // decided on the last column, so the flag lands on column 0 of the next line
   assign hit = line_end && (mem_line == split_line);
endmodule

// File: rtl/raster_status.sv
module raster_status
   import raster_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_en,
   input  logic [7:0] st_sel,
   input  logic       irq_en,
   input  logic       hit,
   input  logic       hblank,
   input  logic       vblank,
   output logic       line_flag,
   output logic [7:0] rd_data,
   output logic       irq
);
   logic flag_rd;

   assign flag_rd = rd_en && (st_sel == SEL_LINE);

   always_ff @(posedge clk) begin
      if (!rst_n)       line_flag <= 1'b0;
      else if (hit)     line_flag <= 1'b1;   // a new match outranks the read
      else if (flag_rd) line_flag <= 1'b0;
   end

   always_comb begin
      rd_data = '0;
      case (st_sel)
         SEL_LINE:  rd_data[LINE_FLAG_BIT] = line_flag;
         SEL_BLANK: begin
            rd_data[HB_BIT] = hblank;
            rd_data[VB_BIT] = vblank;
         end
         default:   rd_data = '0;
      endcase
   end

   assign irq = line_flag & irq_en;

   AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> line_flag);                                           // R4
   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (line_flag && !flag_rd) |=> line_flag);                       // R5
   AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_rd && !hit) |=> !line_flag);                            // R6
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !line_flag |-> !irq);                                         // R7
endmodule

// File: rtl/raster_split_irq.sv
module raster_split_irq #(
   parameter int H_TOTAL  = 342,
   parameter int H_ACTIVE = 256,
   parameter int H_LEFT   = 43,
   parameter int V_TOTAL  = 262,
   parameter int V_ACTIVE = 212,
   parameter int IDX_W    = 6,
   localparam int HW = $clog2(H_TOTAL),
   localparam int VW = $clog2(V_TOTAL)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic             rd_en,
   output logic [7:0]       rd_data,
   output logic             irq,
   output logic [HW-1:0]    hcount,
   output logic [VW-1:0]    vcount,
   output logic             hblank,
   output logic             vblank
);
   logic       line_end;
   logic       irq_en;
   logic [7:0] st_sel;
   logic [7:0] split_line;
   logic [7:0] vscroll;
   logic       hit;
   logic       line_flag;

   raster_timing #(
      .H_TOTAL(H_TOTAL), .H_ACTIVE(H_ACTIVE), .H_LEFT(H_LEFT),
      .V_TOTAL(V_TOTAL), .V_ACTIVE(V_ACTIVE)
   ) u_timing (
      .clk(clk), .rst_n(rst_n), .hcnt(hcount), .vcnt(vcount),
      .line_end(line_end), .hblank(hblank), .vblank(vblank)
   );

   raster_regs #(.IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .irq_en(irq_en), .st_sel(st_sel),
      .split_line(split_line), .vscroll(vscroll)
   );

   raster_line_cmp u_cmp (
      .line_lo(vcount[7:0]), .vscroll(vscroll), .split_line(split_line),
      .line_end(line_end), .hit(hit)
   );

   raster_status u_status (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .st_sel(st_sel),
      .irq_en(irq_en), .hit(hit), .hblank(hblank), .vblank(vblank),
      .line_flag(line_flag), .rd_data(rd_data), .irq(irq)
   );

   AST_FLAG_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_flag) |-> hcount == '0);                           // R4
endmodule

// File: tb/raster_split_irq_tb.sv
module raster_split_irq_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [5:0] wr_idx = '0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       irq;
   logic [8:0] hcount;
   logic [8:0] vcount;
   logic       hblank;
   logic       vblank;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   raster_split_irq u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq),
      .hcount(hcount), .vcount(vcount), .hblank(hblank), .vblank(vblank)
   );

   // blanking vectors in raster order: line, column, hblank, vblank
   localparam int NV = 8;
   localparam int VL [NV] = '{60, 60, 60, 60, 60, 211, 212, 261};
   localparam int VC [NV] = '{0, 42, 43, 298, 299, 341, 0, 341};
   localparam int VH [NV] = '{1, 1, 0, 0, 1, 1, 1, 1};
   localparam int VV [NV] = '{0, 0, 0, 0, 0, 0, 1, 1};

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wreg(input int idx, input int val);
      wr_en = 1'b1; wr_idx = 6'(idx); wr_data = 8'(val);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_pos(input int l, input int c);
      while (!(vcount == 9'(l) && hcount == 9'(c))) @(negedge clk);
   endtask

   // one-cycle clearing read; returns value seen
   task automatic rd_pulse(output int val);
      rd_en = 1'b1; #1 val = int'(rd_data);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      int v;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 R9 reset state
      chk("R1 hcount reset", int'(hcount), 0);
      chk("R1 vcount reset", int'(vcount), 0);
      chk("R9 irq reset", int'(irq), 0);
      chk("R2 hblank at column 0", int'(hblank), 1);
      chk("R9 selector resets to 0", int'(rd_data), 0);
      @(negedge clk);

      wreg(15, 1);
      #1 chk("R9 selector write visible next cycle", int'(rd_data), 0);
      wreg(19, 5);
      wreg(0, 0);

      // R4 flag not early, then at column 0 of line 6
      wait_pos(5, 341); #1 chk("R4 flag not before next line", int'(rd_data), 0);
      wait_pos(6, 0);   #1 chk("R4 flag at column 0", int'(rd_data), 1);
      chk("R7 no irq with enable bit clear", int'(irq), 0);
      wait_pos(6, 50);  #1 chk("R5 flag held without read", int'(rd_data), 1);
      rd_pulse(v);      chk("R6 read returns flag", v, 1);
      #1 chk("R6 flag cleared after read", int'(rd_data), 0);

      // R7 interrupt level
      wreg(0, 8'h10);
      wreg(19, 10);
      wait_pos(11, 0);   #1 chk("R7 irq asserted with flag", int'(irq), 1);
      wait_pos(11, 200); #1 chk("R7 irq stays high", int'(irq), 1);
      rd_pulse(v);
      #1 chk("R7 irq drops after clearing read", int'(irq), 0);

      // R4 scrolled match: (26 + 250) mod 256 = 20
      wreg(23, 250);
      wreg(19, 20);
      wait_pos(26, 341); #1 chk("R4 scroll no early irq", int'(irq), 0);
      wait_pos(27, 0);   #1 chk("R4 scrolled match", int'(irq), 1);
      rd_pulse(v);

      // R6 set and read in the same cycle: (46 + 250) mod 256 = 40
      wreg(19, 40);
      wait_pos(46, 341);
      rd_pulse(v);
      chk("R6 flag zero before collision", v, 0);
      #1 chk("R6 set wins over read", int'(rd_data), 1);

      // R8 other selections read zero and do not clear
      wreg(15, 0);
      #1 chk("R8 word 0 reads zero", int'(rd_data), 0);
      wreg(15, 7);
      rd_pulse(v);
      chk("R8 selection 7 reads zero", v, 0);
      wreg(15, 1);
      #1 chk("R8 flag survives other reads", int'(rd_data), 1);
      rd_pulse(v);

      // R2 R3 blanking vector walk
      wreg(15, 2);
      for (int i = 0; i < NV; i++) begin
         wait_pos(VL[i], VC[i]);
         #1;
         chk("R2 hblank port", int'(hblank), VH[i]);
         chk("R3 vblank port", int'(vblank), VV[i]);
         chk("R2 R3 status word 2", int'(rd_data), (VV[i] << 6) | (VH[i] << 5));
      end

      // R1 frame wrap
      @(negedge clk); #1;
      chk("R1 hcount wraps", int'(hcount), 0);
      chk("R1 vcount wraps", int'(vcount), 0);
      chk("R3 vblank off at line 0", int'(vblank), 0);
      chk("R7 no irq at frame start", int'(irq), 0);

      done = 1'b1;
      finish_run();
   end
endmodule